// File: doc/BRIEF.md
# Multi-Mode PWM Timer Channel

One 16-bit counting channel that produces two waveform outputs and three interrupt pulses. A clock-enable divider paces the counter. The divider ratio is a power of two from 1 to 1024. Five modes are available:
- an up-counting sawtooth PWM;
- a 50% square wave built on that sawtooth;
- a one-shot pulse;
- a symmetric up/down triangle PWM;
- an asymmetric up/down triangle PWM.

Software reaches the channel through a narrow write port with five addresses:
- 0: control word;
- 1: period;
- 2: compare value A;
- 3: compare value B;
- 4: counter preset.

While the channel is stopped, writes take effect at once. While it runs, period and compare values wait in holding registers. They are copied to the active set only at defined points in the count cycle, so a waveform is never cut mid-cycle.

Control word fields:

| Bits | Field |
|---|---|
| [0] | run |
| [3:1] | mode: 0 square wave, 1 one-shot, 2 sawtooth PWM, 3 symmetric triangle, 4 asymmetric triangle |
| [7:4] | divider select s |
| [8] | divider phase: 0 rising, 1 falling |
| [9] | start level of output A |
| [10] | compare level of output A |
| [11] | start level of output B |
| [12] | compare level of output B |

Valid period and compare values are 1 to 65536. In the sawtooth modes the counter runs from 0 to P-1. In the triangle modes it runs from 0 up to P-1 and back down to 0.

Top module: `pwm_timer_ch`

## Requirements
- R1: After reset the counter reads 0, both outputs are 0, all interrupt outputs are 0 and `running` is 0.
- R2: With run set and divider select s, the counter advances once every 2^s clocks. Any select above 10 acts as 10. The counter does not move between those steps.
- R3: The divider restarts from zero on each start. With phase 0 the first step comes 2^(s-1) clocks after the start. With phase 1 it comes 2^s clocks after the start. With s=0 the counter steps every clock.
- R4: In sawtooth PWM mode (2), with period P and compare value D, the counter cycles 0..P-1. An output shows its start level while the count is below D and its compare level from D upward. A D of P or more keeps the output at its start level for the whole cycle.
- R5: In square-wave mode (0) both outputs use floor(P/2) as compare value and the inverse of the start level as compare level. Per period the output spends floor(P/2) steps at the start level and ceil(P/2) steps at the other level.
- R6: In one-shot mode (1), when the count reaches the period end, the channel clears run and returns the count to 0. It raises `irq_ovf` and holds both outputs at their compare levels until the next control write.
- R7: In modes 0 to 2, period and compare values written while running take effect only from the period wrap that follows the write.
- R8: A period write while stopped zeroes the counter and takes effect at once, as do compare writes while stopped.
- R9: In symmetric triangle mode (3) the count rises 0..P-1 and falls back to 0. The compare level shows while count ≥ D. New values load only when the count returns to 0.
- R10: In asymmetric triangle mode (4) new values load both at the top turn (P-1) and at the bottom turn (0).
- R11: `irq_ovf` is a one-clock pulse in the clock after the wrap step (modes 0 to 2) or after the step onto the top turn (modes 3 and 4). `irq_cmp_a` and `irq_cmp_b` pulse one clock after a step onto the matching compare value.
- R12: A counter-preset write is ignored while running and accepted while stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous reset, active low |
| wr_en | input | 1 | register write strobe |
| wr_addr | input | 3 | register select |
| wr_data | input | 17 | write value |
| wave_a | output | 1 | waveform output A |
| wave_b | output | 1 | waveform output B |
| irq_ovf | output | 1 | wrap / top-turn pulse |
| irq_cmp_a | output | 1 | compare A pulse |
| irq_cmp_b | output | 1 | compare B pulse |
| running | output | 1 | counter is enabled |
| count | output | 16 | current counter value |

## Verification
The sawtooth mode is driven with one compare value inside the period and one beyond it, which separates a correct threshold from an inverted or saturated one. The square wave is tried with an odd and an even period, so that a rounding error in the half-period split shows up only on the odd one. Each buffered-update case writes new values at a point where an immediate load, a load at the wrong turn, and a correct load give different output levels a few clocks later. Two phase settings with select 2, plus an out-of-range select, pin down both the step spacing and its phase.

// File: rtl/pwm_timer_ch.sv
module pwm_timer_ch #(
  parameter int CNT_W      = 16,
  parameter int DIV_STAGES = 10,
  parameter int SEL_W      = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [CNT_W:0]   wr_data,
  output logic             wave_a,
  output logic             wave_b,
  output logic             irq_ovf,
  output logic             irq_cmp_a,
  output logic             irq_cmp_b,
  output logic             running,
  output logic [CNT_W-1:0] count
);
  localparam int PW = CNT_W + 1;
  localparam logic [2:0] M_SQUARE = 3'd0, M_ONESHOT = 3'd1, M_TRI_SYM = 3'd3, M_TRI_ASYM = 3'd4;
  localparam logic [2:0] A_CTRL = 3'd0, A_PERIOD = 3'd1, A_DUTY_A = 3'd2, A_DUTY_B = 3'd3, A_COUNT = 3'd4;
  localparam logic [PW-1:0] FULL_RANGE = PW'(1) << CNT_W;

  logic                  run, edge_fall, dir_up, hold;
  logic [2:0]            mode;
  logic [SEL_W-1:0]      sel;
  logic [3:0]            lv;
  logic [PW-1:0]         per_buf, per_act, dty_buf_a, dty_act_a, dty_buf_b, dty_act_b;
  logic [CNT_W-1:0]      cnt;
  logic [DIV_STAGES-1:0] div_cnt;

  logic [SEL_W-1:0]      sel_c;
  logic [DIV_STAGES-1:0] full_mask, half_mask;
  logic                  tick;

  assign sel_c     = (sel > SEL_W'(DIV_STAGES)) ? SEL_W'(DIV_STAGES) : sel;
  assign full_mask = {DIV_STAGES{1'b1}} >> (SEL_W'(DIV_STAGES) - sel_c);
  assign half_mask = full_mask >> 1;
  assign tick      = run && ((div_cnt & full_mask) == (edge_fall ? full_mask : half_mask));

  logic          tri_m, wrap, at_crest, at_trough, ovf_ev, load_ev, end_ev;
  logic [PW-1:0] cnt_x, pmax, nxt, duty_a, duty_b;

  assign tri_m = (mode == M_TRI_SYM) || (mode == M_TRI_ASYM);
  assign cnt_x = {1'b0, cnt};
  assign pmax  = per_act - PW'(1);
  assign wrap  = cnt_x >= pmax;

  always_comb begin
    if (!tri_m)      nxt = wrap ? '0 : cnt_x + PW'(1);
    else if (dir_up) nxt = cnt_x + PW'(1);
    else             nxt = cnt_x - PW'(1);
  end

  assign at_crest  = tri_m && dir_up && (nxt >= pmax);
  assign at_trough = tri_m && !dir_up && (nxt == '0);
  assign ovf_ev    = tick && (tri_m ? at_crest : wrap);
  assign load_ev   = tick && (at_trough || ((mode == M_TRI_ASYM) && at_crest) || (!tri_m && wrap));
  assign end_ev    = ovf_ev && (mode == M_ONESHOT);

  assign duty_a = (mode == M_SQUARE) ? (per_act >> 1) : dty_act_a;
  assign duty_b = (mode == M_SQUARE) ? (per_act >> 1) : dty_act_b;

  logic st_a, mt_a, st_b, mt_b;
  assign st_a = lv[0];
  assign mt_a = (mode == M_SQUARE) ? ~lv[0] : lv[1];
  assign st_b = lv[2];
  assign mt_b = (mode == M_SQUARE) ? ~lv[2] : lv[3];

  assign wave_a  = hold ? mt_a : ((run && cnt_x >= duty_a) ? mt_a : st_a);
  assign wave_b  = hold ? mt_b : ((run && cnt_x >= duty_b) ? mt_b : st_b);
  assign running = run;
  assign count   = cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run       <= 1'b0;
      edge_fall <= 1'b0;
      dir_up    <= 1'b1;
      hold      <= 1'b0;
      mode      <= M_SQUARE;
      sel       <= '0;
      lv        <= '0;
      per_buf   <= FULL_RANGE;
      per_act   <= FULL_RANGE;
      dty_buf_a <= FULL_RANGE;
      dty_act_a <= FULL_RANGE;
      dty_buf_b <= FULL_RANGE;
      dty_act_b <= FULL_RANGE;
      cnt       <= '0;
      div_cnt   <= '0;
      irq_ovf   <= 1'b0;
      irq_cmp_a <= 1'b0;
      irq_cmp_b <= 1'b0;
    end else begin
      irq_ovf   <= ovf_ev;
      irq_cmp_a <= tick && (nxt == duty_a);
      irq_cmp_b <= tick && (nxt == duty_b);
      div_cnt   <= run ? div_cnt + DIV_STAGES'(1) : '0;

      if (tick) begin
        cnt <= nxt[CNT_W-1:0];
        if (at_crest)  dir_up <= 1'b0;
        if (at_trough) dir_up <= 1'b1;
      end

      if (load_ev) begin
        per_act   <= per_buf;
        dty_act_a <= dty_buf_a;
        dty_act_b <= dty_buf_b;
      end

      if (end_ev) begin
        run  <= 1'b0;
        hold <= 1'b1;
        cnt  <= '0;
      end

      if (wr_en) begin
        case (wr_addr)
          A_CTRL: begin
            run       <= wr_data[0];
            mode      <= wr_data[3:1];
            sel       <= wr_data[4 +: SEL_W];
            edge_fall <= wr_data[8];
            lv        <= wr_data[12:9];
            hold      <= 1'b0;
            if (!run) dir_up <= 1'b1;
          end
          A_PERIOD: begin
            per_buf <= wr_data;
            if (!run) begin
              per_act <= wr_data;
              cnt     <= '0;
            end
          end
          A_DUTY_A: begin
            dty_buf_a <= wr_data;
            if (!run) dty_act_a <= wr_data;
          end
          A_DUTY_B: begin
            dty_buf_b <= wr_data;
            if (!run) dty_act_b <= wr_data;
          end
          A_COUNT: if (!run) cnt <= wr_data[CNT_W-1:0];
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/pwm_timer_ch_chk.sv
module pwm_timer_ch_chk #(
  parameter int CNT_W = 16,
  parameter int PW    = 17
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             tick,
  input logic             load_ev,
  input logic             wr_en,
  input logic             irq_ovf,
  input logic             running,
  input logic             hold,
  input logic [2:0]       wr_addr,
  input logic [2:0]       mode,
  input logic [CNT_W-1:0] cnt,
  input logic [PW-1:0]    per_act
);
  AST_IDLE_CNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !(wr_en && (wr_addr == 3'd1 || wr_addr == 3'd4))) |=> $stable(cnt)); // R12
  AST_NO_STEP_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick) |=> $stable(cnt)); // R2
  AST_PERIOD_BUFFERED: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !load_ev) |=> $stable(per_act)); // R7
  AST_OVF_FOLLOWS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ovf |-> $past(tick)); // R11
  AST_ONESHOT_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ovf && mode == 3'd1 && !$past(wr_en)) |-> (!running && hold)); // R6
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> !running); // R6
endmodule

bind pwm_timer_ch pwm_timer_ch_chk #(.CNT_W(CNT_W), .PW(CNT_W + 1)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .load_ev(load_ev),
  .wr_en(wr_en), .irq_ovf(irq_ovf), .running(running), .hold(hold),
  .wr_addr(wr_addr), .mode(mode), .cnt(cnt), .per_act(per_act)
);

// File: tb/sim_pwm_timer_ch.sv
module sim_pwm_timer_ch;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [16:0] wr_data = '0;
  logic        wave_a, wave_b, irq_ovf, irq_cmp_a, irq_cmp_b, running;
  logic [15:0] count;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pwm_timer_ch u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wave_a(wave_a), .wave_b(wave_b), .irq_ovf(irq_ovf), .irq_cmp_a(irq_cmp_a),
    .irq_cmp_b(irq_cmp_b), .running(running), .count(count)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [16:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [16:0] ctl(input bit go, input int md, input int sl, input bit fall,
                                      input bit sa, input bit ma, input bit sb, input bit mb);
    logic [3:0] s4;
    logic [2:0] m3;
    s4 = sl[3:0];
    m3 = md[2:0];
    return {4'b0, mb, sb, ma, sa, fall, s4, m3, go};
  endfunction

  task automatic t_reset();
    chk("R1 wave_a", int'(wave_a), 0);
    chk("R1 wave_b", int'(wave_b), 0);
    chk("R1 irq_ovf", int'(irq_ovf), 0);
    chk("R1 irq_cmp_a", int'(irq_cmp_a), 0);
    chk("R1 running", int'(running), 0);
    chk("R1 count", int'(count), 0);
  endtask

  task automatic t_prescale();
    wr(1, 17'd100);
    wr(0, ctl(1, 2, 2, 0, 0, 0, 0, 0));
    step(1); chk("R3 rising first step not yet", int'(count), 0);
    step(1); chk("R3 rising first step", int'(count), 1);
    step(3); chk("R2 held between steps", int'(count), 1);
    step(1); chk("R2 second step", int'(count), 2);
    wr(0, ctl(0, 2, 2, 0, 0, 0, 0, 0));
    wr(1, 17'd100);
    wr(0, ctl(1, 2, 2, 1, 0, 0, 0, 0));
    step(3); chk("R3 falling first step not yet", int'(count), 0);
    step(1); chk("R3 falling first step", int'(count), 1);
    step(3); chk("R3 falling held", int'(count), 1);
    step(1); chk("R3 falling second step", int'(count), 2);
    wr(0, ctl(0, 2, 2, 1, 0, 0, 0, 0));
    wr(1, 17'd100);
    wr(0, ctl(1, 2, 15, 0, 0, 0, 0, 0));
    step(511);  chk("R2 clamp before first", int'(count), 0);
    step(1);    chk("R2 clamp first step", int'(count), 1);
    step(1023); chk("R2 clamp held", int'(count), 1);
    step(1);    chk("R2 clamp second step", int'(count), 2);
    wr(0, ctl(0, 2, 0, 0, 0, 0, 0, 0));
  endtask

  task automatic t_pwm();
    wr(1, 17'd5);
    wr(2, 17'd2);
    wr(3, 17'd7);
    wr(0, ctl(1, 2, 0, 0, 1, 0, 0, 1));
    chk("R4 start count", int'(count), 0);
    chk("R4 start wave_a", int'(wave_a), 1);
    for (int k = 1; k <= 10; k++) begin
      int c;
      step(1);
      c = k % 5;
      chk($sformatf("R4 count k=%0d", k), int'(count), c);
      chk($sformatf("R4 wave_a k=%0d", k), int'(wave_a), (c < 2) ? 1 : 0);
      chk($sformatf("R4 wave_b beyond period k=%0d", k), int'(wave_b), 0);
      chk($sformatf("R11 irq_ovf k=%0d", k), int'(irq_ovf), (c == 0) ? 1 : 0);
      chk($sformatf("R11 irq_cmp_a k=%0d", k), int'(irq_cmp_a), (c == 2) ? 1 : 0);
    end
    wr(0, ctl(0, 2, 0, 0, 1, 0, 0, 1));
  endtask

  task automatic t_square(input int p);
    int hi;
    hi = 0;
    wr(1, 17'(p));
    wr(0, ctl(1, 0, 0, 0, 0, 0, 0, 0));
    for (int k = 1; k <= p; k++) begin
      step(1);
      hi += int'(wave_a);
      chk($sformatf("R5 wave_a p=%0d k=%0d", p, k), int'(wave_a), ((k % p) >= (p / 2)) ? 1 : 0);
    end
    chk($sformatf("R5 high steps p=%0d", p), hi, p - p / 2);
    wr(0, ctl(0, 0, 0, 0, 0, 0, 0, 0));
  endtask

  task automatic t_oneshot();
    wr(1, 17'd4);
    wr(2, 17'd1);
    wr(0, ctl(1, 1, 0, 0, 0, 1, 0, 0));
    chk("R6 start wave_a", int'(wave_a), 0);
    chk("R6 start running", int'(running), 1);
    for (int k = 1; k <= 3; k++) begin
      step(1);
      chk($sformatf("R6 count k=%0d", k), int'(count), k);
      chk($sformatf("R6 wave_a k=%0d", k), int'(wave_a), 1);
    end
    step(1);
    chk("R6 self stop", int'(running), 0);
    chk("R6 end irq_ovf", int'(irq_ovf), 1);
    chk("R6 end count", int'(count), 0);
    chk("R6 end level", int'(wave_a), 1);
    step(4);
    chk("R6 still stopped", int'(running), 0);
    chk("R6 level held", int'(wave_a), 1);
    chk("R6 count held", int'(count), 0);
    wr(0, ctl(0, 1, 0, 0, 0, 1, 0, 0));
    chk("R6 hold released", int'(wave_a), 0);
  endtask

  task automatic t_buffer();
    wr(1, 17'd5);
    wr(2, 17'd2);
    wr(0, ctl(1, 2, 0, 0, 1, 0, 0, 0));
    step(1);
    wr(1, 17'd3);
    wr(2, 17'd1);
    chk("R7 period not yet loaded", int'(count), 3);
    chk("R7 duty not yet loaded", int'(wave_a), 0);
    step(1); chk("R7 count 4", int'(count), 4);
    step(1); chk("R7 wrap count", int'(count), 0);
    chk("R7 wrap irq", int'(irq_ovf), 1);
    chk("R7 wrap wave", int'(wave_a), 1);
    step(1); chk("R7 new duty", int'(wave_a), 0);
    step(1); chk("R7 new period count 2", int'(count), 2);
    step(1); chk("R7 new period wrap", int'(count), 0);
    chk("R7 new period irq", int'(irq_ovf), 1);
    wr(0, ctl(0, 2, 0, 0, 1, 0, 0, 0));
    step(3); chk("R12 stopped count frozen", int'(count), 1);
    wr(4, 17'd3); chk("R12 preset accepted when stopped", int'(count), 3);
    wr(1, 17'd9); chk("R8 period write clears count", int'(count), 0);
    wr(0, ctl(1, 2, 0, 0, 1, 0, 0, 0));
    step(8); chk("R8 count 8", int'(count), 8);
    chk("R8 no wrap yet", int'(irq_ovf), 0);
    step(1); chk("R8 wrap at 9", int'(count), 0);
    chk("R8 wrap irq", int'(irq_ovf), 1);
    wr(4, 17'd40); chk("R12 preset ignored when running", int'(count), 1);
    step(1); chk("R12 counting continues", int'(count), 2);
    wr(0, ctl(0, 2, 0, 0, 1, 0, 0, 0));
    wr(4, 17'd40); chk("R12 preset after stop", int'(count), 40);
  endtask

  task automatic t_tri_sym();
    wr(1, 17'd4);
    wr(2, 17'd2);
    wr(0, ctl(1, 3, 0, 0, 0, 1, 0, 0));
    step(1); chk("R9 c1", int'(count), 1); chk("R9 wave c1", int'(wave_a), 0);
    step(1); chk("R9 c2", int'(count), 2); chk("R9 wave c2", int'(wave_a), 1);
    chk("R11 cmp up", int'(irq_cmp_a), 1);
    step(1); chk("R9 crest", int'(count), 3); chk("R11 crest irq", int'(irq_ovf), 1);
    wr(2, 17'd1);
    chk("R9 down c2", int'(count), 2); chk("R9 down wave c2", int'(wave_a), 1);
    chk("R11 cmp down", int'(irq_cmp_a), 1);
    step(1); chk("R9 c1 old duty", int'(wave_a), 0);
    step(1); chk("R9 trough", int'(count), 0); chk("R9 trough no ovf", int'(irq_ovf), 0);
    step(1); chk("R9 new duty at trough", int'(wave_a), 1);
    step(2); chk("R11 second crest", int'(irq_ovf), 1); chk("R9 second crest", int'(count), 3);
    wr(0, ctl(0, 3, 0, 0, 0, 1, 0, 0));
  endtask

  task automatic t_tri_asym();
    wr(1, 17'd4);
    wr(2, 17'd2);
    wr(0, ctl(1, 4, 0, 0, 0, 1, 0, 0));
    step(6); chk("R10 trough", int'(count), 0);
    wr(2, 17'd3);
    chk("R10 c1", int'(count), 1); chk("R10 wave c1", int'(wave_a), 0);
    step(1); chk("R10 old duty up", int'(wave_a), 1);
    step(1); chk("R10 crest", int'(count), 3); chk("R10 crest wave", int'(wave_a), 1);
    step(1); chk("R10 new duty after crest", int'(wave_a), 0);
    chk("R10 down c2", int'(count), 2);
    step(1); chk("R10 c1 down", int'(wave_a), 0);
    wr(0, ctl(0, 4, 0, 0, 0, 1, 0, 0));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_prescale();
    t_pwm();
    t_square(5);
    t_square(4);
    t_oneshot();
    t_buffer();
    t_tri_sym();
    t_tri_asym();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule